// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Parallel Bus Port

This block holds the digital side of a 12-bit successive-approximation converter as a microprocessor sees it. Two active-low style strobes arrive from the bus: a chip select and a read/convert line. Either strobe can start a conversion, depending on the level of the other one. The block then moves an external sampler into hold and runs a binary search, one result bit per clock, from the most significant bit down. Each step drives a trial code to an external DAC and reads back a one-bit comparator decision. The comparator reports 1 when the held input is at or above the trial code.

When the last bit has been decided, the search word is converted from offset binary to two's complement and latched into an output register. The busy flag is released on the same clock edge. The parallel data bus is modelled as a data word plus an output enable. Whenever the enable is off, the data word reads as zero and stands in for a high-impedance bus. Both strobes pass through a two-flop synchroniser before any edge on them is recognised.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After reset, busyN is 1, sampleHold is 0, dataOe is 0, dataOut is 0 and trialCode is 0.
- R2: A falling edge on rdConv while csN is low starts a conversion. busyN goes to 0 and sampleHold goes to 1.
- R3: A falling edge on csN while rdConv is low also starts a conversion.
- R4: A conversion holds busyN at 0 for exactly 12 clock cycles.
- R5: The search runs from the most significant bit down. In the first conversion cycle trialCode is 0x800. Each trial bit is kept when cmpIn is 1 on the following clock and cleared otherwise.
- R6: The latched result equals the offset-binary search result with bit 11 inverted, so an input code c reads back as c XOR 0x800. The result does not change while no new result is being latched.
- R7: dataOe is 0 while a conversion runs, and within 4 clocks after csN goes high or rdConv goes low. dataOut is 0 whenever dataOe is 0.
- R8: While idle, a falling edge on csN with rdConv high turns dataOe on. A rising edge on rdConv with csN low also turns dataOe on.
- R9: When csN is low and rdConv is high as a conversion ends, dataOe is 1 and dataOut holds the new result on the clock edge where busyN rises.
- R10: Start edges on either strobe during a conversion are ignored. The running conversion still lasts 12 cycles and no second conversion follows.
- R11: A strobe edge takes effect on the third rising clock edge after the input changes, because of the two-flop synchroniser and the edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low, asynchronous to clk |
| rdConv | input | 1 | Read (high) / convert (low) strobe, asynchronous to clk |
| cmpIn | input | 1 | Comparator decision: 1 when the held input is at or above trialCode |
| trialCode | output | 12 | Offset-binary trial code driven to the external DAC |
| sampleHold | output | 1 | 1 while the sampler must stay in hold |
| busyN | output | 1 | Busy flag, low while converting |
| dataOut | output | 12 | Two's complement result; zero while the bus is released |
| dataOe | output | 1 | Bus drive enable |

## Verification
The hardest situation to reach is a conversion that ends while the bus is already set up for reading, which is what R9 covers. It needs a start through csN with rdConv low, and then rdConv raised partway through the search, so that no idle read edge can turn the bus on. The stimulus raises rdConv a few cycles into the conversion and samples dataOe and dataOut on the exact cycle where busyN first reads high. A second directed case pulses rdConv inside a running conversion. It checks that the busy window stays exactly 12 cycles long and that no extra conversion follows.

// File: rtl/sar_bus_pkg.sv
package sar_bus_pkg;

  // Strobes from the sequencer to the search datapath
  typedef struct packed {
    logic load;    // start of conversion: set MSB trial
    logic decide;  // resolve the current trial bit from the comparator
    logic latch;   // last decision: capture the formatted result
  } sarStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sarState_t;

endpackage

// File: rtl/sar_bus_sync.sv
module sar_bus_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= RST_VAL;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= RST_VAL;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/sar_bus_ctrl_fsm.sv
module sar_bus_ctrl_fsm
  import sar_bus_pkg::*;
#(
  parameter int W          = 12,
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdConv,
  output sarStrobe_t stb,
  output logic       busyN,
  output logic       sampleHold,
  output logic       oeOn
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  // bit 1 = chip select, bit 0 = read/convert; idle level is high for both
  logic [1:0] strobeSync;
  logic [1:0] strobePrev;
  logic       csS, rcS, csPrev, rcPrev;
  logic       csFall, rcFall, rcRise;
  logic       startReq, readReq;

  sarState_t  stateQ;
  logic [CW-1:0] stepCnt;
  logic       oeQ;

  sar_bus_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_DEPTH),
    .RST_VAL(2'b11)
  ) syncI (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({csN, rdConv}),
    .syncOut(strobeSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrev <= 2'b11;
    else       strobePrev <= strobeSync;
  end

  assign csS    = strobeSync[1];
  assign rcS    = strobeSync[0];
  assign csPrev = strobePrev[1];
  assign rcPrev = strobePrev[0];

  assign csFall = csPrev & ~csS;
  assign rcFall = rcPrev & ~rcS;
  assign rcRise = ~rcPrev & rcS;

  // Either strobe starts a conversion, qualified by the other's level
  assign startReq = (stateQ == ST_IDLE) && ((rcFall && !csS) || (csFall && !rcS));
  assign readReq  = (csFall && rcS) || (rcRise && !csS);

  always_comb begin
    stb        = '0;
    stb.load   = startReq;
    stb.decide = (stateQ == ST_CONV);
    stb.latch  = (stateQ == ST_CONV) && (stepCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (startReq) begin
            stateQ  <= ST_CONV;
            stepCnt <= LAST_IDX;
          end
        end
        ST_CONV: begin
          if (stepCnt == '0) stateQ <= ST_IDLE;
          else               stepCnt <= stepCnt - 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // Bus enable: released during conversion or when a strobe leaves read level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeQ <= 1'b0;
    end else if (stateQ == ST_CONV) begin
      oeQ <= (stepCnt == '0) && !csS && rcS;
    end else if (csS || !rcS || startReq) begin
      oeQ <= 1'b0;
    end else if (readReq) begin
      oeQ <= 1'b1;
    end
  end

  assign busyN      = (stateQ == ST_IDLE);
  assign sampleHold = (stateQ == ST_CONV);
  assign oeOn       = oeQ;

endmodule

// File: rtl/sar_bus_dp.sv
module sar_bus_dp
  import sar_bus_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  sarStrobe_t   stb,
  input  logic         cmpIn,
  input  logic         oeOn,
  output logic [W-1:0] trialCode,
  output logic [W-1:0] dataOut
);

  localparam logic [W-1:0] MSB_ONE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] trialQ;
  logic [W-1:0] maskQ;
  logic [W-1:0] resQ;
  logic [W-1:0] keptV;
  logic [W-1:0] fmtV;

  // Trial bit under test is kept if input >= trial, else cleared
  assign keptV = cmpIn ? trialQ : (trialQ & ~maskQ);
  // Offset binary to two's complement: flip the sign position
  assign fmtV  = keptV ^ MSB_ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialQ <= '0;
      maskQ  <= '0;
      resQ   <= '0;
    end else if (stb.load) begin
      trialQ <= MSB_ONE;
      maskQ  <= MSB_ONE;
    end else if (stb.decide) begin
      maskQ <= maskQ >> 1;
      if (stb.latch) begin
        trialQ <= '0;
        resQ   <= fmtV;
      end else begin
        trialQ <= keptV | (maskQ >> 1);
      end
    end
  end

  assign trialCode = trialQ;
  assign dataOut   = oeOn ? resQ : '0;

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
  import sar_bus_pkg::*;
#(
  parameter int W          = 12,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         rdConv,
  input  logic         cmpIn,
  output logic [W-1:0] trialCode,
  output logic         sampleHold,
  output logic         busyN,
  output logic [W-1:0] dataOut,
  output logic         dataOe
);

  sarStrobe_t stb;
  logic       oeOn;

  sar_bus_ctrl_fsm #(
    .W         (W),
    .SYNC_DEPTH(SYNC_DEPTH)
  ) fsmI (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .rdConv    (rdConv),
    .stb       (stb),
    .busyN     (busyN),
    .sampleHold(sampleHold),
    .oeOn      (oeOn)
  );

  sar_bus_dp #(
    .W(W)
  ) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cmpIn    (cmpIn),
    .oeOn     (oeOn),
    .trialCode(trialCode),
    .dataOut  (dataOut)
  );

  assign dataOe = oeOn;

endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] trialCode,
  input logic         sampleHold,
  input logic         busyN,
  input logic [W-1:0] dataOut,
  input logic         dataOe
);

  localparam int LCW = $clog2(W + 2) + 1;
  logic [LCW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       lowCnt <= '0;
    else if (!busyN) lowCnt <= lowCnt + 1'b1;
    else             lowCnt <= '0;
  end

  // R4: busy window length
  a_r4_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyN) |-> (lowCnt == LCW'(W)));

  // R4: no busy window longer than W
  a_r4_busy_bound: assert property (@(posedge clk) disable iff (!rstN)
    !busyN |-> (lowCnt < LCW'(W)));

  // R5: first trial is the MSB alone
  a_r5_msb_first: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyN) |-> (trialCode == {1'b1, {(W-1){1'b0}}}));

  // R7: bus released while converting
  a_r7_oe_idle_only: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> busyN);

  // R7: released bus reads as zero
  a_r7_zero_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0));

  // R2: hold flag tracks conversion
  a_r2_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    sampleHold |-> !busyN);

  // R6: result steady while idle and driven
  a_r6_result_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busyN && $past(busyN) && dataOe && $past(dataOe)) |-> $stable(dataOut));

endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.W(W)) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .trialCode (trialCode),
  .sampleHold(sampleHold),
  .busyN     (busyN),
  .dataOut   (dataOut),
  .dataOe    (dataOe)
);

// File: tb/sar_bus_ctrl_test.sv
`timescale 1ns/1ps
module sar_bus_ctrl_test;

  localparam int W = 12;
  localparam int NV = 8;
  // {start mode, input code}; mode 0 = convert edge, mode 1 = select edge
  localparam logic [W:0] VEC [NV] = '{
    {1'b0, 12'h000}, {1'b1, 12'hFFF}, {1'b0, 12'h800}, {1'b1, 12'h7FF},
    {1'b0, 12'hA5A}, {1'b1, 12'h123}, {1'b0, 12'h001}, {1'b1, 12'hFFE}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic rdConv = 1'b1;
  logic cmpIn;
  logic [W-1:0] trialCode;
  logic sampleHold, busyN, dataOe;
  logic [W-1:0] dataOut;
  logic [W-1:0] inCode = '0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  // ideal comparator against the stored input code
  assign cmpIn = (inCode >= trialCode);

  sar_bus_ctrl #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdConv(rdConv), .cmpIn(cmpIn),
    .trialCode(trialCode), .sampleHold(sampleHold), .busyN(busyN),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count negedges until busyN reads 0
  task automatic waitBusy(output int delay);
    delay = 0;
    while (busyN && delay < 50) begin
      @(negedge clk);
      delay++;
    end
  endtask

  // count negedges busyN stays 0 (first low sample included)
  task automatic countLow(output int lowCnt);
    lowCnt = 1;
    @(negedge clk);
    while (!busyN && lowCnt < 100) begin
      lowCnt++;
      @(negedge clk);
    end
  endtask

  task automatic toIdle();
    csN = 1'b1; rdConv = 1'b1;
    waitN(5);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int d, lc;
    logic [W-1:0] expV;

    waitN(3);
    // R1: reset state
    chk("R1 busyN", busyN, 1);
    chk("R1 sampleHold", sampleHold, 0);
    chk("R1 dataOe", dataOe, 0);
    chk("R1 dataOut", dataOut, 0);
    chk("R1 trialCode", trialCode, 0);
    rstN = 1'b1;
    waitN(4);

    for (int i = 0; i < NV; i++) begin
      inCode = VEC[i][W-1:0];
      expV   = VEC[i][W-1:0] ^ 12'h800;
      if (!VEC[i][W]) begin
        csN = 1'b0; waitN(5);
        rdConv = 1'b0;                  // R2 convert edge
      end else begin
        rdConv = 1'b0; waitN(5);
        csN = 1'b0;                     // R3 select edge
      end
      waitBusy(d);
      chk(VEC[i][W] ? "R3 start latency R11" : "R2 start latency R11", d, 3);
      chk("R2 sampleHold during conversion", sampleHold, 1);
      chk("R5 first trial MSB", trialCode, 12'h800);
      countLow(lc);
      chk("R4 busy length", lc, 12);
      chk("R7 oe off with rdConv low", dataOe, 0);
      if (!VEC[i][W]) begin
        rdConv = 1'b1; waitN(4);        // R8 read by rising convert line
      end else begin
        csN = 1'b1; waitN(4);
        rdConv = 1'b1; waitN(4);
        csN = 1'b0; waitN(4);           // R8 read by falling select
      end
      chk("R8 oe on", dataOe, 1);
      chk("R6 result", dataOut, expV);
      csN = 1'b1; waitN(4);
      chk("R7 oe off after select high", dataOe, 0);
      chk("R7 data zero when off", dataOut, 0);
      toIdle();
    end

    // R9: rdConv raised mid-conversion; data valid at busy rise
    inCode = 12'h3C5;
    rdConv = 1'b0; waitN(5);
    csN = 1'b0;
    waitBusy(d);
    waitN(3);
    chk("R7 oe off during conversion", dataOe, 0);
    rdConv = 1'b1;
    lc = 0;
    while (!busyN && lc < 50) begin
      @(negedge clk); lc++;
    end
    chk("R9 oe at busy rise", dataOe, 1);
    chk("R9 data at busy rise", dataOut, 12'h3C5 ^ 12'h800);
    toIdle();

    // R10: extra start edges during conversion ignored
    inCode = 12'h456;
    csN = 1'b0; waitN(5);
    rdConv = 1'b0;
    waitBusy(d);
    lc = 1;
    @(negedge clk); lc++;
    rdConv = 1'b1;
    @(negedge clk); lc++;
    @(negedge clk); lc++;
    rdConv = 1'b0;                      // convert edge while busy
    @(negedge clk);
    while (!busyN && lc < 100) begin
      lc++;
      @(negedge clk);
    end
    chk("R10 busy length unchanged", lc, 12);
    waitN(10);
    chk("R10 no second conversion", busyN, 1);
    rdConv = 1'b1; waitN(4);
    chk("R10 result of first conversion", dataOut, 12'h456 ^ 12'h800);
    // R7: rdConv low releases bus
    rdConv = 1'b0; waitN(4);
    chk("R7 oe off after convert low", dataOe, 0);
    toIdle();

    // R11: edge not yet seen two cycles after the change
    csN = 1'b0; waitN(5);
    rdConv = 1'b0;
    waitN(2);
    chk("R11 no start before third edge", busyN, 1);
    waitN(1);
    chk("R11 start on third edge", busyN, 0);
    countLow(lc);
    toIdle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule